// File: doc/BRIEF.md
# Interleaved PFC/PWM Gate Timing Generator

This block is the digital timing core of a two-stage power converter controller. A free-running master oscillator, built as a counter on the system clock, is divided by a chain of toggle flip-flops. The result drives two gate outputs: one for a boost power-factor-correction (PFC) stage and one for a downstream forward converter (PWM stage). The PFC stage switches at one quarter of the master rate. A strap selects whether the PWM stage switches at that same rate or at twice it (half the master rate).

The PFC gate uses leading-edge modulation: its on-time grows backwards from a fixed turn-off instant. The PWM gate uses trailing-edge modulation: it turns on at a fixed instant and its turn-off moves with the command. The two stages are interleaved so that the PFC turn-off and the PWM turn-on fall on the same clock edge. Each stage has a cycle-by-cycle current-limit flag that cuts its gate until the next cycle of that stage. The PWM flag is blanked just after turn-on.

Duty commands are unsigned counts of system-clock cycles, and each stage samples its command only at its own cycle start. The PWM command has a built-in offset, so small commands give zero duty.

Top module: `pfc_pwm_timer`

## Requirements
- R1: The PFC cycle lasts 4·2^OSC_BITS clock cycles (PER). `pfc_start` is high for exactly one cycle per PFC cycle, in slot 0. Slot k is the k-th clock cycle after the `pfc_start` cycle.
- R2: With `ratio_sel`=0, the PWM cycle equals PER and `pwm_start` is in slot PER−DEAD_CNT. With `ratio_sel`=1, the PWM cycle is PER/2 and `pwm_start` is in slots PER/2−DEAD_CNT and PER−DEAD_CNT. The PWM gate rises only in a `pwm_start` slot.
- R3: The PFC gate is high in slots PER−DEAD_CNT−w through PER−DEAD_CNT−1, where w is the sampled `pfc_duty`. A duty of 0 keeps the gate low.
- R4: The PFC on-time is capped at PER−DEAD_CNT slots, so the last DEAD_CNT slots of every PFC cycle are always low.
- R5: The PFC gate falls on the same clock edge on which the PWM gate rises at slot PER−DEAD_CNT.
- R6: From each `pwm_start` slot, the PWM gate is high for `pwm_cmd`−PWM_OFFSET slots. A command at or below PWM_OFFSET gives no pulse.
- R7: The PWM on-time is capped at half the PWM period minus DEAD_CNT slots.
- R8: `pfc_ilim` high in one cycle forces the PFC gate low from the next slot until the next PFC cycle start. The gate returns to normal in the following cycle.
- R9: `pwm_ilim` forces the PWM gate low until the next `pwm_start`. The flag is ignored while the gate is in PWM slots 0 to BLANK_CNT−1 of its cycle.
- R10: A change to `pfc_duty` or `pwm_cmd` after its stage's start slot has no effect on the current cycle. It takes effect in the next cycle.
- R11: With `enable` low, all four outputs are low from the next edge and the divider restarts. After `enable` rises, the next edge gives the PFC slot 0.
- R12: While `rst_n` is low, all outputs are low. After release with `enable` high, the first edge gives PFC slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one master count per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low holds gates low and restarts the divider |
| ratio_sel | input | 1 | 0: PWM rate equals PFC rate; 1: PWM rate is twice the PFC rate |
| pfc_duty | input | CMD_W | PFC on-time in clock cycles |
| pwm_cmd | input | CMD_W | PWM command; on-time is command minus PWM_OFFSET |
| pfc_ilim | input | 1 | PFC cycle-by-cycle current-limit flag |
| pwm_ilim | input | 1 | PWM cycle-by-cycle current-limit flag |
| pfc_gate | output | 1 | PFC gate drive (leading-edge modulated) |
| pwm_gate | output | 1 | PWM gate drive (trailing-edge modulated) |
| pfc_start | output | 1 | One-cycle strobe at each PFC cycle start |
| pwm_start | output | 1 | One-cycle strobe at each PWM cycle start |

## Verification
Slot-by-slot traces are compared for these command patterns:
- mid-range commands in both ratio modes, which separate the two PWM tap points;
- zero and minimum-nonzero commands, which expose an off-by-one in the window edges or in the offset;
- full-scale commands, which show whether the dead-time and half-period caps clip in the right slot.

Current-limit pulses placed one slot either side of the blanking boundary tell an ignored flag from an honoured one. Commands changed right after a start slot show whether sampling happens only at cycle start. Toggling `enable` mid-pulse confirms the synchronous restart phase.

// File: rtl/pfc_pwm_pkg.sv
// Shared types for the PFC/PWM timing generator.
package pfc_pwm_pkg;
    // Rate relation between the two stages, as set by the strap.
    typedef enum logic {
        RATIO_SAME   = 1'b0,
        RATIO_DOUBLE = 1'b1
    } ratio_e;
endpackage

// File: rtl/pfc_pwm_phase.sv
// Master oscillator counter plus a toggle flip-flop divider chain.
// The output phase is {toggle stages, oscillator count}, so it counts
// through one full PFC cycle of 2^(OSC_BITS+STAGES) clocks.
// Assumes: enable low or rst_n low restarts everything at phase 0.
module pfc_pwm_phase #(
    parameter int OSC_BITS = 5,
    parameter int STAGES   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    output logic [OSC_BITS+STAGES-1:0] phase
);
    logic [OSC_BITS-1:0] osc_q;
    logic [STAGES-1:0]   tff_q;
    logic [STAGES-1:0]   carry;

    // Each stage toggles when all lower stages and the oscillator wrap.
    assign carry[0] = &osc_q;
    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_carry
            assign carry[i] = carry[i-1] & tff_q[i-1];
        end
    endgenerate

    // Master oscillator: free-running count, one master tick per wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) osc_q <= '0;
        else                   osc_q <= osc_q + OSC_BITS'(1);
    end

    // Toggle divider chain, clocked by the oscillator wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            tff_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                if (carry[i]) tff_q[i] <= ~tff_q[i];
            end
        end
    end

    assign phase = {tff_q, osc_q};

    // First divider stage must flip on every oscillator wrap.
    assert_div_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && carry[0]) |=> (!enable || (tff_q[0] != $past(tff_q[0]))));
endmodule

// File: rtl/pfc_pwm_pfc_gate.sv
// Leading-edge PFC gate: on-window ends at a fixed slot (PER-DEAD_CNT)
// and starts earlier as the duty grows. Duty is sampled at phase 0.
// A current-limit flag cuts the gate until the next phase 0.
// Assumes: phase comes from pfc_pwm_phase and steps by one per clock.
module pfc_pwm_pfc_gate #(
    parameter int PER_BITS = 7,
    parameter int DEAD_CNT = 2,
    parameter int CMD_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PER_BITS-1:0] phase,
    input  logic [CMD_W-1:0]    duty,
    input  logic                ilim,
    output logic                gate,
    output logic                cyc_start
);
    localparam int PER    = 1 << PER_BITS;
    localparam int MAX_ON = PER - DEAD_CNT;
    localparam int WW     = (CMD_W > PER_BITS) ? CMD_W + 1 : PER_BITS + 1;
    localparam logic [WW-1:0] MAX_ON_W = WW'(MAX_ON);

    logic [WW-1:0] duty_w, phase_w, width_now, width_q, width_eff, on_from;
    logic          top_slot, hold_q, hold_nxt, in_win;
    logic [WW-1:0] run_q;

    assign duty_w    = WW'(duty);
    assign phase_w   = WW'(phase);
    assign top_slot  = (phase == '0);
    // Clip the command to leave the dead time in every cycle.
    assign width_now = (duty_w > MAX_ON_W) ? MAX_ON_W : duty_w;
    assign width_eff = top_slot ? width_now : width_q;
    assign on_from   = MAX_ON_W - width_eff;
    assign in_win    = (phase_w >= on_from) && (phase_w < MAX_ON_W);
    // Limit latch: cleared at cycle start, set by the flag in any slot.
    assign hold_nxt  = (hold_q & ~top_slot) | ilim;

    // Register width, limit latch, gate and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            width_q   <= '0;
            hold_q    <= 1'b0;
            gate      <= 1'b0;
            cyc_start <= 1'b0;
        end else begin
            width_q   <= width_eff;
            hold_q    <= hold_nxt;
            gate      <= in_win & ~hold_nxt;
            cyc_start <= top_slot;
        end
    end

    // Checker: length of the current high run of the gate.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) run_q <= '0;
        else if (gate)         run_q <= run_q + WW'(1);
        else                   run_q <= '0;
    end

    assert_pfc_run_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= MAX_ON_W);
    assert_pfc_ilim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ilim) |=> !gate);
endmodule

// File: rtl/pfc_pwm_pwm_gate.sv
// Trailing-edge PWM gate: turns on at its cycle start and off after the
// sampled width. Its cycle is offset from the PFC cycle by DEAD_CNT so
// that turn-on coincides with PFC turn-off. In double-rate mode the top
// divider stage is masked, so the cycle repeats every half PFC period.
// Assumes: ratio_dbl changes only while enable is low.
module pfc_pwm_pwm_gate #(
    parameter int PER_BITS   = 7,
    parameter int DEAD_CNT   = 2,
    parameter int BLANK_CNT  = 4,
    parameter int PWM_OFFSET = 16,
    parameter int CMD_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                ratio_dbl,
    input  logic [PER_BITS-1:0] phase,
    input  logic [CMD_W-1:0]    cmd,
    input  logic                ilim,
    output logic                gate,
    output logic                cyc_start
);
    localparam int PER   = 1 << PER_BITS;
    localparam int WW    = (CMD_W > PER_BITS) ? CMD_W + 1 : PER_BITS + 1;
    localparam logic [WW-1:0] CAP_SAME = WW'(PER / 2 - DEAD_CNT);
    localparam logic [WW-1:0] CAP_DBL  = WW'(PER / 4 - DEAD_CNT);
    localparam logic [WW-1:0] OFF_W    = WW'(PWM_OFFSET);
    localparam logic [WW-1:0] BLANK_W  = WW'(BLANK_CNT);

    logic [PER_BITS-1:0] shifted, pos;
    logic [WW-1:0]       pos_w, cmd_w, cap, net, width_now, width_q, width_eff;
    logic                start_now, blank_over, hold_q, hold_nxt;
    logic [WW-1:0]       run_q;

    // Local PWM position: PFC phase advanced by the dead time, folded.
    assign shifted    = phase + PER_BITS'(DEAD_CNT);
    assign pos        = ratio_dbl ? {1'b0, shifted[PER_BITS-2:0]} : shifted;
    assign pos_w      = WW'(pos);
    assign start_now  = (pos == '0);
    // Built-in offset, then the just-under-half-period cap.
    assign cmd_w      = WW'(cmd);
    assign cap        = ratio_dbl ? CAP_DBL : CAP_SAME;
    assign net        = (cmd_w > OFF_W) ? (cmd_w - OFF_W) : '0;
    assign width_now  = (net > cap) ? cap : net;
    assign width_eff  = start_now ? width_now : width_q;
    // Limit flag counts only after the blanking window.
    assign blank_over = (pos_w >= BLANK_W);
    assign hold_nxt   = (hold_q & ~start_now) | (ilim & blank_over);

    // Register width, limit latch, gate and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            width_q   <= '0;
            hold_q    <= 1'b0;
            gate      <= 1'b0;
            cyc_start <= 1'b0;
        end else begin
            width_q   <= width_eff;
            hold_q    <= hold_nxt;
            gate      <= (pos_w < width_eff) & ~hold_nxt;
            cyc_start <= start_now;
        end
    end

    // Checker: length of the current high run of the gate.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) run_q <= '0;
        else if (gate)         run_q <= run_q + WW'(1);
        else                   run_q <= '0;
    end

    assert_pwm_run_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= cap);
    assert_pwm_ilim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ilim && blank_over) |=> !gate);
    assert_pwm_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_now && (cmd_w <= OFF_W)) |=> !gate);
endmodule

// File: rtl/pfc_pwm_timer.sv
// Top of the interleaved PFC/PWM gate timing generator. One phase
// generator feeds a leading-edge PFC gate and a trailing-edge PWM gate.
// Assumes: ratio_sel is a strap, changed only while enable is low.
module pfc_pwm_timer #(
    parameter int OSC_BITS   = 5,
    parameter int DEAD_CNT   = 2,
    parameter int BLANK_CNT  = 4,
    parameter int PWM_OFFSET = 16,
    parameter int CMD_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ratio_sel,
    input  logic [CMD_W-1:0] pfc_duty,
    input  logic [CMD_W-1:0] pwm_cmd,
    input  logic             pfc_ilim,
    input  logic             pwm_ilim,
    output logic             pfc_gate,
    output logic             pwm_gate,
    output logic             pfc_start,
    output logic             pwm_start
);
    import pfc_pwm_pkg::*;

    localparam int STAGES   = 2;
    localparam int PER_BITS = OSC_BITS + STAGES;

    logic [PER_BITS-1:0] phase;
    ratio_e              ratio_mode;

    assign ratio_mode = ratio_e'(ratio_sel);

    pfc_pwm_phase #(
        .OSC_BITS (OSC_BITS),
        .STAGES   (STAGES)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .phase  (phase)
    );

    pfc_pwm_pfc_gate #(
        .PER_BITS (PER_BITS),
        .DEAD_CNT (DEAD_CNT),
        .CMD_W    (CMD_W)
    ) u_pfc (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .phase     (phase),
        .duty      (pfc_duty),
        .ilim      (pfc_ilim),
        .gate      (pfc_gate),
        .cyc_start (pfc_start)
    );

    pfc_pwm_pwm_gate #(
        .PER_BITS   (PER_BITS),
        .DEAD_CNT   (DEAD_CNT),
        .BLANK_CNT  (BLANK_CNT),
        .PWM_OFFSET (PWM_OFFSET),
        .CMD_W      (CMD_W)
    ) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .ratio_dbl (ratio_mode == RATIO_DOUBLE),
        .phase     (phase),
        .cmd       (pwm_cmd),
        .ilim      (pwm_ilim),
        .gate      (pwm_gate),
        .cyc_start (pwm_start)
    );

    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pfc_gate && !pwm_gate && !pfc_start && !pwm_start));
    assert_pwm_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_gate) |-> pwm_start);
    assert_pfc_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pfc_start |=> !pfc_start);
endmodule

// File: tb/pfc_pwm_timer_tb.sv
module pfc_pwm_timer_tb;
    localparam int OSC_BITS = 5;
    localparam int DEAD     = 2;
    localparam int BLANK    = 4;
    localparam int OFFSET   = 16;
    localparam int CMD_W    = 8;
    localparam int PER      = 1 << (OSC_BITS + 2);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, enable, ratio_sel, pfc_ilim, pwm_ilim;
    logic [CMD_W-1:0] pfc_duty, pwm_cmd;
    logic pfc_gate, pwm_gate, pfc_start, pwm_start;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    pfc_pwm_timer #(
        .OSC_BITS (OSC_BITS), .DEAD_CNT (DEAD), .BLANK_CNT (BLANK),
        .PWM_OFFSET (OFFSET), .CMD_W (CMD_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .enable (enable), .ratio_sel (ratio_sel),
        .pfc_duty (pfc_duty), .pwm_cmd (pwm_cmd), .pfc_ilim (pfc_ilim),
        .pwm_ilim (pwm_ilim), .pfc_gate (pfc_gate), .pwm_gate (pwm_gate),
        .pfc_start (pfc_start), .pwm_start (pwm_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pfc_exp(input int k, input int w);
        int wc = (w > PER - DEAD) ? PER - DEAD : w;
        return int'((k >= PER - DEAD - wc) && (k < PER - DEAD));
    endfunction

    function automatic int pwm_width(input int c, input bit dbl);
        int n   = (c > OFFSET) ? c - OFFSET : 0;
        int cap = (dbl ? PER / 4 : PER / 2) - DEAD;
        return (n > cap) ? cap : n;
    endfunction

    function automatic int pwm_pos(input int k, input bit dbl);
        return (k + DEAD) % (dbl ? PER / 2 : PER);
    endfunction

    task automatic restart(input bit dbl);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        ratio_sel = dbl;
        enable = 1'b1;
    endtask

    task automatic sync_pfc();
        @(negedge clk);
        while (pfc_start !== 1'b1) @(negedge clk);
    endtask

    task automatic sync_pwm();
        @(negedge clk);
        while (pwm_start !== 1'b1) @(negedge clk);
    endtask

    // Full-cycle trace compare of all four outputs against the requirements.
    task automatic run_pattern(input string req, input int pw, input int pc, input bit dbl);
        int slot_a = -1, act_a = 0, exp_a = 0;
        int slot_b = -1, act_b = 0, exp_b = 0;
        int slot_c = -1, act_c = 0, exp_c = 0;
        pfc_duty = CMD_W'(pw);
        pwm_cmd  = CMD_W'(pc);
        restart(dbl);
        repeat (2 * PER) @(negedge clk);
        sync_pfc();
        for (int k = 0; k < PER; k++) begin
            int e_pfc, e_pwm, e_st;
            if (k > 0) @(negedge clk);
            e_pfc = pfc_exp(k, pw);
            e_pwm = int'(pwm_pos(k, dbl) < pwm_width(pc, dbl));
            e_st  = int'(pwm_pos(k, dbl) == 0) * 2 + int'(k == 0);
            if (int'(pfc_gate) != e_pfc && slot_a < 0) begin
                slot_a = k; act_a = int'(pfc_gate); exp_a = e_pfc;
            end
            if (int'(pwm_gate) != e_pwm && slot_b < 0) begin
                slot_b = k; act_b = int'(pwm_gate); exp_b = e_pwm;
            end
            if ((int'(pwm_start) * 2 + int'(pfc_start)) != e_st && slot_c < 0) begin
                slot_c = k; act_c = int'(pwm_start) * 2 + int'(pfc_start); exp_c = e_st;
            end
        end
        check(slot_a < 0, req, $sformatf("pfc_gate slot %0d", slot_a), act_a, exp_a);
        check(slot_b < 0, req, $sformatf("pwm_gate slot %0d", slot_b), act_b, exp_b);
        check(slot_c < 0, {req, " R1 R2"}, $sformatf("strobes slot %0d", slot_c), act_c, exp_c);
    endtask

    // R1 and R2: strobe spacing in both ratio modes.
    task automatic test_periods();
        int n;
        pfc_duty = 8'd50; pwm_cmd = 8'(OFFSET + 10);
        restart(1'b0);
        sync_pfc();
        n = 0;
        do begin @(negedge clk); n++; end while (pfc_start !== 1'b1);
        check(n == PER, "R1", "pfc_start spacing", n, PER);
        restart(1'b1);
        repeat (PER) @(negedge clk);
        sync_pwm();
        n = 0;
        do begin @(negedge clk); n++; end while (pwm_start !== 1'b1);
        check(n == PER / 2, "R2", "pwm_start spacing 1:2", n, PER / 2);
    endtask

    // R5: PFC off and PWM on at the same edge.
    task automatic test_interleave();
        pfc_duty = 8'd60; pwm_cmd = 8'(OFFSET + 30);
        restart(1'b0);
        repeat (2 * PER) @(negedge clk);
        sync_pfc();
        repeat (PER - DEAD - 1) @(negedge clk);
        check(pfc_gate && !pwm_gate, "R5", "before handover {pfc,pwm}",
              int'({pfc_gate, pwm_gate}), 2);
        @(negedge clk);
        check(!pfc_gate && pwm_gate && pwm_start, "R5", "at handover {pfc,pwm}",
              int'({pfc_gate, pwm_gate}), 1);
    endtask

    // R8: PFC limit cuts the rest of the cycle, then re-arms.
    task automatic test_pfc_ilim();
        int n;
        pfc_duty = 8'd100; pwm_cmd = 8'(OFFSET + 20);
        restart(1'b0);
        repeat (2 * PER) @(negedge clk);
        sync_pfc();
        repeat (50) @(negedge clk);
        check(pfc_gate == 1'b1, "R8", "gate on before limit", int'(pfc_gate), 1);
        pfc_ilim = 1'b1;
        @(negedge clk);
        pfc_ilim = 1'b0;
        check(pfc_gate == 1'b0, "R8", "gate slot after limit", int'(pfc_gate), 0);
        n = 0;
        for (int k = 52; k < PER; k++) begin @(negedge clk); n += int'(pfc_gate); end
        check(n == 0, "R8", "on slots rest of cycle", n, 0);
        n = 0;
        for (int k = 0; k < PER; k++) begin @(negedge clk); n += int'(pfc_gate); end
        check(n == 100, "R8", "on slots next cycle", n, 100);
    endtask

    // R9: PWM limit pulse during local slot s; blanking decides effect.
    task automatic test_pwm_ilim(input int s, input int exp_on);
        int n = 0;
        pfc_duty = 8'd20; pwm_cmd = 8'(OFFSET + 40);
        restart(1'b0);
        repeat (2 * PER) @(negedge clk);
        sync_pwm();
        for (int j = 0; j < PER; j++) begin
            if (j > 0) @(negedge clk);
            n += int'(pwm_gate);
            pwm_ilim = (j == s);
        end
        pwm_ilim = 1'b0;
        check(n == exp_on, "R9", $sformatf("pwm on slots, limit in slot %0d", s), n, exp_on);
        n = 0;
        for (int j = 0; j < PER; j++) begin @(negedge clk); n += int'(pwm_gate); end
        check(n == 40, "R9", "pwm on slots after re-arm", n, 40);
    endtask

    // R10: commands changed right after their start slot wait a cycle.
    task automatic test_sampling();
        int n;
        pfc_duty = 8'd40; pwm_cmd = 8'(OFFSET + 20);
        restart(1'b0);
        repeat (2 * PER) @(negedge clk);
        sync_pfc();
        pfc_duty = 8'd90;
        n = 0;
        for (int k = 0; k < PER; k++) begin
            if (k > 0) @(negedge clk);
            n += int'(pfc_gate);
        end
        check(n == 40, "R10", "pfc on slots, changed cycle", n, 40);
        n = 0;
        for (int k = 0; k < PER; k++) begin @(negedge clk); n += int'(pfc_gate); end
        check(n == 90, "R10", "pfc on slots, next cycle", n, 90);
        sync_pwm();
        pwm_cmd = 8'(OFFSET + 50);
        n = 0;
        for (int k = 0; k < PER; k++) begin
            if (k > 0) @(negedge clk);
            n += int'(pwm_gate);
        end
        check(n == 20, "R10", "pwm on slots, changed cycle", n, 20);
        n = 0;
        for (int k = 0; k < PER; k++) begin @(negedge clk); n += int'(pwm_gate); end
        check(n == 50, "R10", "pwm on slots, next cycle", n, 50);
    endtask

    // R11: enable drop mid-pulse and restart phase.
    task automatic test_enable();
        int n = 0;
        pfc_duty = 8'd60; pwm_cmd = 8'(OFFSET + 30);
        restart(1'b0);
        repeat (2 * PER) @(negedge clk);
        while (pfc_gate !== 1'b1) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check({pfc_gate, pwm_gate, pfc_start, pwm_start} == 4'b0, "R11",
              "outputs after enable low", int'({pfc_gate, pwm_gate, pfc_start, pwm_start}), 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            n += int'(pfc_gate | pwm_gate | pfc_start | pwm_start);
        end
        check(n == 0, "R11", "active slots while disabled", n, 0);
        enable = 1'b1;
        @(negedge clk);
        check(pfc_start && !pfc_gate && !pwm_gate, "R11", "first slot after enable",
              int'({pfc_start, pfc_gate, pwm_gate}), 4);
        n = 0;
        while (pwm_start !== 1'b1) begin @(negedge clk); n++; end
        check(n == PER - DEAD, "R11", "slots to first pwm_start", n, PER - DEAD);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b1; ratio_sel = 1'b0;
        pfc_duty = 8'd30; pwm_cmd = 8'(OFFSET + 10);
        pfc_ilim = 1'b0; pwm_ilim = 1'b0;
        repeat (5) @(negedge clk);
        check({pfc_gate, pwm_gate, pfc_start, pwm_start} == 4'b0, "R12",
              "outputs in reset", int'({pfc_gate, pwm_gate, pfc_start, pwm_start}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pfc_start == 1'b1, "R12", "pfc_start first slot after reset", int'(pfc_start), 1);

        test_periods();
        run_pattern("R3 R6", 60, OFFSET + 30, 1'b0);
        run_pattern("R3 R6 R2", 10, OFFSET + 20, 1'b1);
        run_pattern("R3 R6 zero", 0, OFFSET, 1'b0);
        run_pattern("R3 R6 min", 1, OFFSET + 1, 1'b1);
        run_pattern("R4 R7", 255, 255, 1'b0);
        run_pattern("R4 R7 1:2", 200, 255, 1'b1);
        test_interleave();
        test_pfc_ilim();
        test_pwm_ilim(1, 40);
        test_pwm_ilim(2, 40);
        test_pwm_ilim(3, 4);
        test_pwm_ilim(10, 11);
        test_sampling();
        test_enable();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule